// File: doc/BRIEF.md
# Adder Oracle String Array

This block answers serial addition queries without adding anything at run time. It holds a bank of pre-built strings. Each string is a chain of tiles, and each tile carries three constant bits: one operand bit, another operand bit and one sum bit. The constants of one string are built as a ripple chain, so every tile's carry-out feeds the carry-in of the tile above it, and the bottom tile starts from a carry of zero. String number i encodes operand A = i mod 2^W and operand B = i div 2^W, with the sum (A+B) mod 2^W. The default bank of 200 strings leaves the queries whose index B*2^W+A is 200 or more without an answer.

A query is shifted in one bit per cycle into the latches of every string at once. A start pulse then sends an enable down each string, one tile per cycle. A tile whose latched query bits differ from its constants blocks the enable. At the bottom tile the enable turns around and climbs back up as a return enable. A string whose return reaches its top tile has matched: it latches its sum bits and raises its match flag. Its sum bits then travel down the string and out of the bottom tile, one per cycle. The serial outputs of all strings are ORed into one ringer output with a valid strobe. A separate flag reports a query that no string answered.

Top module: `adder_oracle_array`

## Requirements
- R1: While idle, a cycle with `q_shift` high and `q_start` low moves `q_a`/`q_b` into the top tile of every string and every held bit one tile down. After W such cycles fed LSB first, bit k of each operand sits in tile k.
- R2: `q_start` while idle makes `busy` high from the next cycle for exactly 3*W cycles: 2*W for the enable's round trip and W for the serial output.
- R3: String i answers only when the latched query equals A = i mod 2^W and B = i div 2^W. Bit i of `match_o` is then 1 and every other bit is 0.
- R4: `match_o` and `no_match` are cleared in the cycle after the start edge. They take their result 2*W cycles after the start edge and hold it until the next start.
- R5: `no_match` is 1 exactly when no string answered the finished query.
- R6: When a string answers, `sum_valid` is high for W consecutive cycles beginning 2*W cycles after the start edge, and `sum_bit` carries (A+B) mod 2^W LSB first.
- R7: When no string answers, `sum_valid` and `sum_bit` stay 0 for the whole evaluation.
- R8: While `busy` is high, `q_shift` and `q_start` have no effect. A later start with no new load gives the previous query's result.
- R9: Synchronous active-low reset, including in the middle of an evaluation, leaves `busy`, `match_o`, `no_match` and `sum_valid` at 0.
- R10: At most one bit of `match_o` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_shift | input | 1 | Shift one query bit pair into all strings |
| q_a | input | 1 | Serial bit of operand A, LSB first |
| q_b | input | 1 | Serial bit of operand B, LSB first |
| q_start | input | 1 | Launch evaluation of the loaded query |
| busy | output | 1 | Evaluation or shift-out in progress |
| match_o | output | NSTR | Per-string answer flag |
| no_match | output | 1 | No string answered the last query |
| sum_bit | output | 1 | Ringer output, sum bits LSB first |
| sum_valid | output | 1 | `sum_bit` carries a sum bit |

## Verification
Two things can happen in the same cycle: the enable round trip or the serial sum output, and a fresh query shift or start pulse arriving from outside. The bench provokes this by holding `q_shift`, `q_start`, `q_a` and `q_b` high through every busy cycle of one evaluation. It judges the result in two ways. The busy window must still end after exactly 3*W cycles with the correct answer. A following start with no reload must then return the same sum and match flag, which shows that no latched query bit was disturbed.

// File: rtl/oracle_pkg.sv
// Shared types and constant generators for the adder oracle.
// Assumes W is small enough that 2*W fits in an int unsigned index.
package oracle_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_SHIFT = 2'd2
    } ctrl_state_e;

    // Constants {a, b, s} of tile j in string idx, built by ripple from carry zero.
    function automatic logic [2:0] tile_consts(input int unsigned idx,
                                               input int unsigned w,
                                               input int unsigned j);
        int unsigned a_v;
        int unsigned b_v;
        logic        cy;
        logic        ab;
        logic        bb;
        logic        sb;
        a_v = idx % (32'd1 << w);
        b_v = (idx >> w) % (32'd1 << w);
        cy  = 1'b0;
        ab  = 1'b0;
        bb  = 1'b0;
        sb  = 1'b0;
        for (int unsigned k = 0; k <= j; k++) begin
            ab = a_v[k];
            bb = b_v[k];
            sb = ab ^ bb ^ cy;
            cy = (ab & bb) | (cy & (ab ^ bb));
        end
        return {ab, bb, sb};
    endfunction

endpackage

// File: rtl/oracle_ctrl.sv
// Shared sequencer for all strings: gates query shifts and starts, times the
// 2*W-cycle enable round trip and the W-cycle serial sum output.
// Assumes every string has the same tile count W.
module oracle_ctrl
    import oracle_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic q_shift,
    input  logic q_start,
    output logic busy,
    output logic shift_en,
    output logic go,
    output logic load,
    output logic shifting
);

    localparam int unsigned CW         = $clog2(2 * W + 1);
    localparam logic [CW-1:0] EVAL_LAST  = CW'(2 * W - 1);
    localparam logic [CW-1:0] SHIFT_LAST = CW'(W - 1);

    ctrl_state_e   state;
    logic [CW-1:0] cnt;

    assign busy     = (state != ST_IDLE);
    assign go       = q_start & ~busy;
    assign shift_en = q_shift & ~busy & ~q_start;
    assign load     = (state == ST_EVAL) && (cnt == EVAL_LAST);
    assign shifting = (state == ST_SHIFT);

    // Phase sequencer: idle -> enable round trip -> serial output -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (q_start) begin
                        state <= ST_EVAL;
                        cnt   <= '0;
                    end
                end
                ST_EVAL: begin
                    if (cnt == EVAL_LAST) begin
                        state <= ST_SHIFT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cnt == SHIFT_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R2: a start taken while idle makes the block busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && q_start) |=> busy);

    // R2: evaluation never outruns its round-trip window
    p_eval_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL) |-> (cnt <= EVAL_LAST));

endmodule

// File: rtl/oracle_tile.sv
// One tile: latches one query bit pair, passes the down-going enable only on a
// match with its constants, relays the returning enable upward, and holds one
// sum bit that shifts toward the bottom of the string.
// Assumes the string feeds a_in/b_in/s_in from the tile above.
module oracle_tile #(
    parameter logic TA = 1'b0,
    parameter logic TB = 1'b0,
    parameter logic TS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic a_in,
    input  logic b_in,
    input  logic go_in,
    input  logic ret_in,
    input  logic clear,
    input  logic load,
    input  logic resp,
    input  logic sum_shift,
    input  logic s_in,
    output logic a_q,
    output logic b_q,
    output logic go_out,
    output logic ret_out,
    output logic s_q
);

    logic match;
    assign match = (a_q == TA) && (b_q == TB);

    // Query latches: shift one position down when loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else if (shift_en) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    // Enable relay: block the downward pass on mismatch, forward the return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_out  <= 1'b0;
            ret_out <= 1'b0;
        end else begin
            go_out  <= go_in & match;
            ret_out <= ret_in;
        end
    end

    // Sum latch: clear at start, capture on answer, then shift downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= 1'b0;
        end else if (clear) begin
            s_q <= 1'b0;
        end else if (load) begin
            s_q <= TS & resp;
        end else if (sum_shift) begin
            s_q <= s_in;
        end
    end

endmodule

// File: rtl/oracle_string.sv
// One pre-built string of W tiles encoding A = IDX mod 2^W, B = IDX div 2^W.
// Tile W-1 is the top (query entry, enable entry); tile 0 is the bottom
// (enable turnaround, sum exit).
module oracle_string
    import oracle_pkg::*;
#(
    parameter int unsigned W   = 4,
    parameter int unsigned IDX = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic q_a,
    input  logic q_b,
    input  logic go,
    input  logic load,
    input  logic sum_shift,
    output logic resp,
    output logic hit,
    output logic ser_bit
);

    localparam int unsigned A_VAL = IDX % (2 ** W);
    localparam int unsigned B_VAL = (IDX / (2 ** W)) % (2 ** W);
    localparam logic [W-1:0] A_CONST = A_VAL[W-1:0];
    localparam logic [W-1:0] B_CONST = B_VAL[W-1:0];

    logic [W-1:0] a_c, b_c, go_c, ret_c, s_c;
    logic [W-1:0] a_src, b_src, go_src, ret_src, s_src;
    logic [W-1:0] a_word, b_word;

    assign a_word = a_c;
    assign b_word = b_c;
    assign resp   = ret_c[W-1];
    assign ser_bit = s_c[0];

    for (genvar j = 0; j < W; j++) begin : g_tile
        localparam logic [2:0] K = tile_consts(IDX, W, j);

        if (j == W - 1) begin : g_top
            assign a_src[j]  = q_a;
            assign b_src[j]  = q_b;
            assign go_src[j] = go;
            assign s_src[j]  = 1'b0;
        end else begin : g_mid
            assign a_src[j]  = a_c[j+1];
            assign b_src[j]  = b_c[j+1];
            assign go_src[j] = go_c[j+1];
            assign s_src[j]  = s_c[j+1];
        end

        if (j == 0) begin : g_turn
            assign ret_src[j] = go_c[0];
        end else begin : g_up
            assign ret_src[j] = ret_c[j-1];
        end

        oracle_tile #(
            .TA(K[2]),
            .TB(K[1]),
            .TS(K[0])
        ) u_tile (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .a_in     (a_src[j]),
            .b_in     (b_src[j]),
            .go_in    (go_src[j]),
            .ret_in   (ret_src[j]),
            .clear    (go),
            .load     (load),
            .resp     (resp),
            .sum_shift(sum_shift),
            .s_in     (s_src[j]),
            .a_q      (a_c[j]),
            .b_q      (b_c[j]),
            .go_out   (go_c[j]),
            .ret_out  (ret_c[j]),
            .s_q      (s_c[j])
        );
    end

    // Answer flag: cleared at start, set when the return reaches the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else if (go) begin
            hit <= 1'b0;
        end else if (load && resp) begin
            hit <= 1'b1;
        end
    end

    // R3: a return reaching the top means every tile matched the query
    p_resp_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp |-> (a_word == A_CONST) && (b_word == B_CONST));

    // R8: the latched query is not disturbed after an enable enters
    p_query_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go_c[W-1] |=> ($stable(a_word) && $stable(b_word)));

endmodule

// File: rtl/adder_oracle_array.sv
// Bank of NSTR pre-built addition strings sharing one sequencer. Queries are
// broadcast serially; the matching string rings out its stored sum.
// Assumes NSTR <= 2^(2*W) so every string index encodes a distinct query.
module adder_oracle_array #(
    parameter int unsigned W    = 4,
    parameter int unsigned NSTR = 200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_shift,
    input  logic            q_a,
    input  logic            q_b,
    input  logic            q_start,
    output logic            busy,
    output logic [NSTR-1:0] match_o,
    output logic            no_match,
    output logic            sum_bit,
    output logic            sum_valid
);

    logic            shift_en, go, load, shifting;
    logic [NSTR-1:0] resp_vec, ser_vec;

    oracle_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_shift (q_shift),
        .q_start (q_start),
        .busy    (busy),
        .shift_en(shift_en),
        .go      (go),
        .load    (load),
        .shifting(shifting)
    );

    for (genvar i = 0; i < NSTR; i++) begin : g_str
        oracle_string #(.W(W), .IDX(i)) u_str (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .q_a      (q_a),
            .q_b      (q_b),
            .go       (go),
            .load     (load),
            .sum_shift(shifting),
            .resp     (resp_vec[i]),
            .hit      (match_o[i]),
            .ser_bit  (ser_vec[i])
        );
    end

    // Miss flag: cleared at start, set at the end of the round trip if silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_match <= 1'b0;
        end else if (go) begin
            no_match <= 1'b0;
        end else if (load) begin
            no_match <= ~|resp_vec;
        end
    end

    assign sum_valid = shifting & (|match_o);
    assign sum_bit   = shifting & (|ser_vec);

    // R10: strings encode distinct queries, so at most one answers
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_o));

    // R5: a miss report never coexists with an answering string
    p_miss_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> (match_o == '0));

    // R7: no serial output without an answering string
    p_valid_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid || sum_bit) |-> !no_match);

    // R6: serial output only during a busy phase
    p_valid_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |-> busy);

endmodule

// File: tb/tb_adder_oracle_array.sv
module tb_adder_oracle_array;

    localparam int unsigned W    = 4;
    localparam int unsigned NSTR = 200;
    localparam time CLK_PERIOD   = 10ns;
    localparam int NVEC          = 10;

    // Each entry is {A, B}; expected results are computed from the requirements.
    localparam logic [7:0] VEC [NVEC] = '{
        {4'd3,  4'd5 },
        {4'd0,  4'd0 },
        {4'd15, 4'd11},
        {4'd7,  4'd12},
        {4'd8,  4'd12},
        {4'd15, 4'd15},
        {4'd1,  4'd1 },
        {4'd9,  4'd6 },
        {4'd2,  4'd13},
        {4'd15, 4'd0 }
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            q_shift = 1'b0;
    logic            q_a = 1'b0;
    logic            q_b = 1'b0;
    logic            q_start = 1'b0;
    logic            busy;
    logic [NSTR-1:0] match_o;
    logic            no_match;
    logic            sum_bit;
    logic            sum_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adder_oracle_array #(.W(W), .NSTR(NSTR)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_shift  (q_shift),
        .q_a      (q_a),
        .q_b      (q_b),
        .q_start  (q_start),
        .busy     (busy),
        .match_o  (match_o),
        .no_match (no_match),
        .sum_bit  (sum_bit),
        .sum_valid(sum_valid)
    );

    function automatic int first_set(input logic [NSTR-1:0] v);
        for (int i = 0; i < NSTR; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_query(input logic [W-1:0] a, input logic [W-1:0] b);
        for (int i = 0; i < int'(W); i++) begin
            q_shift = 1'b1;
            q_a = a[i];
            q_b = b[i];
            @(negedge clk);
        end
        q_shift = 1'b0;
        q_a = 1'b0;
        q_b = 1'b0;
    endtask

    // Start, then judge busy window, match flags and serial sum.
    task automatic run_eval(input int a, input int b, input bit noise);
        int              idx;
        bit              hit;
        logic [W-1:0]    s_exp;
        logic [W-1:0]    got;
        logic [NSTR-1:0] expv;
        idx   = b * (2 ** W) + a;
        hit   = (idx < int'(NSTR));
        s_exp = W'((a + b) % (2 ** W));
        expv  = '0;
        if (hit) expv[idx] = 1'b1;
        got = '0;
        q_start = 1'b1;
        @(negedge clk);
        q_start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        chk(match_o == '0, "R4", "match cleared at start", first_set(match_o), -1);
        chk(no_match == 1'b0, "R4", "miss cleared at start", longint'(no_match), 0);
        if (noise) begin
            q_shift = 1'b1;
            q_start = 1'b1;
            q_a = 1'b1;
            q_b = 1'b1;
        end
        repeat (2 * W) @(negedge clk);
        chk(match_o == expv, "R3", "answering string", first_set(match_o), hit ? idx : -1);
        chk(no_match == !hit, "R5", "miss flag", longint'(no_match), longint'(!hit));
        for (int k = 0; k < int'(W); k++) begin
            chk(sum_valid == hit, hit ? "R6" : "R7", "sum_valid", longint'(sum_valid), longint'(hit));
            got[k] = sum_bit;
            if (k < int'(W) - 1) @(negedge clk);
        end
        chk(got == (hit ? s_exp : '0), hit ? "R6" : "R7", "serial sum", longint'(got),
            hit ? longint'(s_exp) : 0);
        @(negedge clk);
        q_shift = 1'b0;
        q_start = 1'b0;
        q_a = 1'b0;
        q_b = 1'b0;
        chk(busy == 1'b0, noise ? "R8" : "R2", "busy ends after 3W", longint'(busy), 0);
        @(negedge clk);
        chk(match_o == expv, "R4", "match held", first_set(match_o), hit ? idx : -1);
        chk(no_match == !hit, "R4", "miss held", longint'(no_match), longint'(!hit));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", "busy in reset", longint'(busy), 0);
        chk(match_o == '0, "R9", "match in reset", first_set(match_o), -1);
        chk(no_match == 1'b0, "R9", "miss in reset", longint'(no_match), 0);
        chk(sum_valid == 1'b0, "R9", "valid in reset", longint'(sum_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R3/R5/R6/R7: table walk, each query loaded LSB first
        for (int v = 0; v < NVEC; v++) begin
            load_query(VEC[v][7:4], VEC[v][3:0]);
            run_eval(int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0);
        end

        // R8: inputs hammered during busy; then re-run without reload
        run_eval(15, 0, 1'b1);
        run_eval(15, 0, 1'b0);

        // R9: reset during evaluation
        load_query(4'd3, 4'd5);
        q_start = 1'b1;
        @(negedge clk);
        q_start = 1'b0;
        repeat (W) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after mid reset", longint'(busy), 0);
        chk(match_o == '0, "R9", "match after mid reset", first_set(match_o), -1);
        chk(sum_valid == 1'b0, "R9", "valid after mid reset", longint'(sum_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reload after reset and confirm a fresh answer
        load_query(4'd6, 4'd2);
        run_eval(6, 2, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule